// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the codec-side deserializer for the controller-to-codec direction of a fixed-rate serial audio link. It watches a frame marker and a single serial data line, both launched by the controller on rising edges of the bit clock. It samples both on falling edges and cuts each 256-bit frame into a 16-bit tag followed by twelve 20-bit slots. Three kinds of parallel event come out of the frame: register writes (index plus 16-bit data), register read requests (index only), and left and right 18-bit playback samples.

The tag carries a frame-valid flag and one valid flag for each of the first four slots. An event is produced only when the frame flag and the flags of the slots it draws on are set. Each event appears on its own strobe for exactly one bit clock, as soon as the last bit it depends on has been sampled. The output streams are valid-only. The serial line cannot be stalled, so there is no ready input and no back-pressure. A consumer must take each beat in the single bit clock it is shown. Within one frame, events are at least 20 bit clocks apart. Index, data and sample outputs hold their last value between strobes.

All logic runs on the falling edge of `bit_clk`. `rst_n` is an asynchronous active-low reset.

Top module: `sfr_frame_rx`

## Requirements
- R1: While `rst_n` is low and after its release, all strobes are low and `wr_idx`, `wr_data`, `rd_idx`, `pcm_l` and `pcm_r` are zero. Until the first rising edge of `sync`, serial data produces no strobe.
- R2: Rising-edge detection of `sync` is done on falling edges. The bit sampled on the falling edge that follows the one where `sync` is first seen high is frame bit 0, which is tag bit 15. Frame bit p is sampled p+1 falling edges after that detection edge. A frame is 256 bits long, with slot n starting at bit 16+20(n-1), and bits arriving after bit 255 without a new `sync` rise are ignored. Only one strobe is ever high at a time.
- R3: When tag bit 15 (frame valid) is 0, the frame produces no strobe and leaves every held output unchanged.
- R4: If tag bits 15, 14 and 13 are all 1 and slot 1 bit 19 is 0, `wr_valid` is high for one bit clock starting at the falling edge that samples frame bit 55. In that cycle `wr_idx` is slot 1 bits 18:12 and `wr_data` is slot 2 bits 19:4.
- R5: If tag bits 15 and 14 are 1 and slot 1 bit 19 is 1, `rd_valid` is high for one bit clock starting at the falling edge that samples frame bit 35, with `rd_idx` equal to slot 1 bits 18:12. `rd_idx` then holds until the next read request.
- R6: No write is issued when tag bit 14 or tag bit 13 is 0, or when slot 1 bit 19 is 1, even if slot 2 is flagged valid.
- R7: If tag bits 15 and 12 are 1, `pcm_l_valid` pulses for one bit clock at the edge that samples frame bit 75, with `pcm_l` equal to slot 3 bits 19:2. If tag bits 15 and 11 are 1, `pcm_r_valid` behaves the same way at frame bit 95, with slot 4. A lane whose flag is 0 keeps its previous sample.
- R8: Tag bits 10:0, slot 1 bits 11:0, slot 2 bits 3:0, bits 1:0 of slots 3 and 4, and all of slots 5 to 12 have no effect on any output.
- R9: A `sync` rise in the middle of a frame restarts the bit count at frame bit 0 and discards the old tag and slot 1 state. No event of the cut frame that was still pending fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame marker; a rising edge starts a frame |
| sdata | input | 1 | Serial frame data, MSB first |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_idx | output | 7 | Register index of the write |
| wr_data | output | 16 | Register write data |
| rd_valid | output | 1 | One-cycle register read request strobe |
| rd_idx | output | 7 | Register index of the last read request, held |
| pcm_l_valid | output | 1 | One-cycle strobe for a new left sample |
| pcm_l | output | 18 | Left playback sample, held |
| pcm_r_valid | output | 1 | One-cycle strobe for a new right sample |
| pcm_r | output | 18 | Right playback sample, held |

## Verification
A bit counter that slips by even one position misaligns every slot field. At the ports this appears within the same frame as an index or sample shifted by one bit, and as a strobe one bit clock early or late, so strobe positions are measured against the `sync` rise. A stale tag or stale slot 1 state shows only in the next frame: a strobe fires from a frame whose valid flag is clear, or a write follows a cut frame. The invalid-frame and restart scenarios are aimed at that. Lost hold registers show as `rd_idx` or a sample lane changing in a frame that did not address it.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_t;

  // position of the last bit of data slot n (n >= 1) in the frame
  function automatic int slot_last(input int tag_w, input int slot_w, input int n);
    return tag_w + slot_w * n - 1;
  endfunction

endpackage

// File: rtl/sfr_frame_timer.sv
module sfr_frame_timer
  import sfr_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int PW        = $clog2(FRAME_LEN)
) (
  input  logic          bit_clk,
  input  logic          rst_n,
  input  logic          sync,
  output logic          restart,
  output logic          bit_en,
  output logic [PW-1:0] bit_pos
);

  logic          sync_q;
  run_t          state;
  logic [PW-1:0] cnt;

  assign restart = sync & ~sync_q;
  assign bit_en  = (state == ST_RUN) & ~restart;
  assign bit_pos = cnt;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      state  <= ST_IDLE;
      cnt    <= '0;
    end else begin
      sync_q <= sync;
      if (restart) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (state == ST_RUN) begin
        if (cnt == PW'(FRAME_LEN - 1)) state <= ST_IDLE;
        else                           cnt   <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int W = 20
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdata,
  output logic [W-1:0] word
);

  logic [W-2:0] hist;

  // newest bit on the right; word holds the last W bits including this one
  assign word = {hist, sdata};

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= word[W-2:0];
  end

endmodule

// File: rtl/sfr_slot_decode.sv
module sfr_slot_decode
  import sfr_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int PCM_W  = 18,
  parameter int PW     = 8
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bit_en,
  input  logic [PW-1:0]     bit_pos,
  input  logic [SLOT_W-1:0] word,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              pcm_l_valid,
  output logic [PCM_W-1:0]  pcm_l,
  output logic              pcm_r_valid,
  output logic [PCM_W-1:0]  pcm_r
);

  localparam int FLAGS = 5;  // frame flag plus four slot flags
  localparam int P_TAG = TAG_W - 1;
  localparam int P_S1  = slot_last(TAG_W, SLOT_W, 1);
  localparam int P_S2  = slot_last(TAG_W, SLOT_W, 2);

  // flags[4] frame, flags[3..0] slots 1..4
  logic [FLAGS-1:0] flags;
  logic             s1_ok;
  logic             rw_q;
  logic [IDX_W-1:0] idx_q;
  logic             unused_word;

  assign unused_word = ^word;

  logic at_tag, at_s1, at_s2, frame_ok;
  assign at_tag   = bit_en && (bit_pos == PW'(P_TAG));
  assign at_s1    = bit_en && (bit_pos == PW'(P_S1));
  assign at_s2    = bit_en && (bit_pos == PW'(P_S2));
  assign frame_ok = flags[FLAGS-1];

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      s1_ok    <= 1'b0;
      rw_q     <= 1'b0;
      idx_q    <= '0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_idx   <= '0;
    end else begin
      wr_valid <= 1'b0;
      rd_valid <= 1'b0;
      if (restart) begin
        flags <= '0;
        s1_ok <= 1'b0;
      end else begin
        if (at_tag) flags <= word[TAG_W-1 -: FLAGS];
        if (at_s1 && frame_ok && flags[3]) begin
          s1_ok <= 1'b1;
          rw_q  <= word[SLOT_W-1];
          idx_q <= word[SLOT_W-2 -: IDX_W];
          if (word[SLOT_W-1]) begin
            rd_valid <= 1'b1;
            rd_idx   <= word[SLOT_W-2 -: IDX_W];
          end
        end
        if (at_s2 && frame_ok && s1_ok && !rw_q && flags[2]) begin
          wr_valid <= 1'b1;
          wr_idx   <= idx_q;
          wr_data  <= word[SLOT_W-1 -: DATA_W];
        end
      end
    end
  end

  // playback lanes: lane 0 is slot 3 (left), lane 1 is slot 4 (right)
  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    localparam int P_END = slot_last(TAG_W, SLOT_W, 3 + ch);
    logic             hit;
    logic             v_q;
    logic [PCM_W-1:0] d_q;

    assign hit = bit_en && (bit_pos == PW'(P_END)) && frame_ok && flags[1-ch];

    always_ff @(negedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= hit;
        if (hit) d_q <= word[SLOT_W-1 -: PCM_W];
      end
    end
  end

  assign pcm_l_valid = g_lane[0].v_q;
  assign pcm_l       = g_lane[0].d_q;
  assign pcm_r_valid = g_lane[1].v_q;
  assign pcm_r       = g_lane[1].d_q;

endmodule

// File: rtl/sfr_frame_rx.sv
module sfr_frame_rx #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 16,
  parameter int PCM_W   = 18
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              sdata,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              pcm_l_valid,
  output logic [PCM_W-1:0]  pcm_l,
  output logic              pcm_r_valid,
  output logic [PCM_W-1:0]  pcm_r
);

  localparam int FRAME_LEN = TAG_W + SLOT_W * N_SLOTS;
  localparam int PW        = $clog2(FRAME_LEN);

  logic              restart;
  logic              bit_en;
  logic [PW-1:0]     bit_pos;
  logic [SLOT_W-1:0] word;

  sfr_frame_timer #(
    .FRAME_LEN(FRAME_LEN),
    .PW       (PW)
  ) u_timer (
    .bit_clk(bit_clk),
    .rst_n  (rst_n),
    .sync   (sync),
    .restart(restart),
    .bit_en (bit_en),
    .bit_pos(bit_pos)
  );

  sfr_shifter #(
    .W(SLOT_W)
  ) u_shift (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .shift_en(bit_en),
    .sdata   (sdata),
    .word    (word)
  );

  sfr_slot_decode #(
    .TAG_W (TAG_W),
    .SLOT_W(SLOT_W),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .PCM_W (PCM_W),
    .PW    (PW)
  ) u_decode (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .bit_en     (bit_en),
    .bit_pos    (bit_pos),
    .word       (word),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_idx     (rd_idx),
    .pcm_l_valid(pcm_l_valid),
    .pcm_l      (pcm_l),
    .pcm_r_valid(pcm_r_valid),
    .pcm_r      (pcm_r)
  );

endmodule

// File: rtl/sfr_frame_rx_chk.sv
module sfr_frame_rx_chk
  import sfr_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 16,
  parameter int PCM_W   = 18
) (
  input logic              bit_clk,
  input logic              rst_n,
  input logic              sync,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              pcm_l_valid,
  input logic [PCM_W-1:0]  pcm_l,
  input logic              pcm_r_valid,
  input logic [PCM_W-1:0]  pcm_r
);

  localparam int FRAME_LEN = TAG_W + SLOT_W * N_SLOTS;
  localparam int K_W       = $clog2(FRAME_LEN) + 1;
  localparam int K_MAX     = (1 << K_W) - 1;
  // a strobe is seen one edge after the edge sampling bit p, i.e. p+2 edges after the rise
  localparam int K_RD = slot_last(TAG_W, SLOT_W, 1) + 2;
  localparam int K_WR = slot_last(TAG_W, SLOT_W, 2) + 2;
  localparam int K_PL = slot_last(TAG_W, SLOT_W, 3) + 2;
  localparam int K_PR = slot_last(TAG_W, SLOT_W, 4) + 2;

  logic           sync_q;
  logic [K_W-1:0] k;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      k      <= '0;
    end else begin
      sync_q <= sync;
      if (sync && !sync_q)                        k <= K_W'(1);
      else if (k != '0 && k != K_W'(K_MAX))       k <= k + 1'b1;
    end
  end

  assert_wr_slot_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    wr_valid |-> (k == K_W'(K_WR)));
  assert_wr_pulse_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_wr_hold_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !wr_valid |-> $stable(wr_data));
  assert_rd_slot_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    rd_valid |-> (k == K_W'(K_RD)));
  assert_rd_hold_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_idx));
  assert_pcm_l_slot_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    pcm_l_valid |-> (k == K_W'(K_PL)));
  assert_pcm_r_slot_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    pcm_r_valid |-> (k == K_W'(K_PR)));
  assert_pcm_hold_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (!pcm_l_valid && !pcm_r_valid) |-> ($stable(pcm_l) && $stable(pcm_r)));
  assert_one_event_R2: assert property (@(negedge bit_clk) disable iff (!rst_n)
    $onehot0({wr_valid, rd_valid, pcm_l_valid, pcm_r_valid}));

endmodule

bind sfr_frame_rx sfr_frame_rx_chk #(
  .TAG_W  (TAG_W),
  .SLOT_W (SLOT_W),
  .N_SLOTS(N_SLOTS),
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W),
  .PCM_W  (PCM_W)
) u_chk (
  .bit_clk    (bit_clk),
  .rst_n      (rst_n),
  .sync       (sync),
  .wr_valid   (wr_valid),
  .wr_data    (wr_data),
  .rd_valid   (rd_valid),
  .rd_idx     (rd_idx),
  .pcm_l_valid(pcm_l_valid),
  .pcm_l      (pcm_l),
  .pcm_r_valid(pcm_r_valid),
  .pcm_r      (pcm_r)
);

// File: tb/test_sfr_frame_rx.sv
module test_sfr_frame_rx;

  localparam int CLK_P = 10;

  logic        bit_clk;
  logic        rst_n;
  logic        sync;
  logic        sdata;
  logic        wr_valid;
  logic [6:0]  wr_idx;
  logic [15:0] wr_data;
  logic        rd_valid;
  logic [6:0]  rd_idx;
  logic        pcm_l_valid;
  logic [17:0] pcm_l;
  logic        pcm_r_valid;
  logic [17:0] pcm_r;

  sfr_frame_rx i_sfr_frame_rx (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .sdata      (sdata),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_idx     (rd_idx),
    .pcm_l_valid(pcm_l_valid),
    .pcm_l      (pcm_l),
    .pcm_r_valid(pcm_r_valid),
    .pcm_r      (pcm_r)
  );

  initial bit_clk = 1'b0;
  always #(CLK_P/2) bit_clk = ~bit_clk;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // frame image
  logic [15:0] f_tag;
  logic [19:0] f_slot [1:12];
  time         t0 = 0;

  // monitor: counts and positions (bit clocks after the sync launch)
  int wr_n = 0, rd_n = 0, pl_n = 0, pr_n = 0;
  int wr_pos = 0, rd_pos = 0, pl_pos = 0, pr_pos = 0;
  int w0, r0, l0, q0;

  always @(posedge bit_clk) begin
    if (wr_valid)    begin wr_n++; wr_pos = int'(($time - t0) / CLK_P); end
    if (rd_valid)    begin rd_n++; rd_pos = int'(($time - t0) / CLK_P); end
    if (pcm_l_valid) begin pl_n++; pl_pos = int'(($time - t0) / CLK_P); end
    if (pcm_r_valid) begin pr_n++; pr_pos = int'(($time - t0) / CLK_P); end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_tag(input bit f, input bit a, input bit b, input bit c, input bit d);
    return {f, a, b, c, d, 11'h000};
  endfunction

  function automatic logic [19:0] s1_wr(input logic [6:0] idx);
    return {1'b0, idx, 12'h000};
  endfunction

  function automatic logic [19:0] s1_rd(input logic [6:0] idx);
    return {1'b1, idx, 12'h000};
  endfunction

  function automatic logic [19:0] s2_dat(input logic [15:0] d);
    return {d, 4'h0};
  endfunction

  task automatic load(input logic [15:0] tg, input logic [19:0] a, input logic [19:0] b,
                      input logic [19:0] c, input logic [19:0] d, input logic [19:0] fill);
    f_tag     = tg;
    f_slot[1] = a;
    f_slot[2] = b;
    f_slot[3] = c;
    f_slot[4] = d;
    for (int s = 5; s <= 12; s++) f_slot[s] = fill;
  endtask

  function automatic logic fbit(input int i);
    int s, b;
    if (i < 16) return f_tag[15 - i];
    s = (i - 16) / 20 + 1;
    b = 19 - ((i - 16) % 20);
    return f_slot[s][b];
  endfunction

  // sync launched on one rising edge, bit i on the (i+1)th rising edge after it
  task automatic send_frame(input int nbits);
    @(posedge bit_clk);
    sync <= 1'b1;
    t0 = $time;
    for (int i = 0; i < nbits; i++) begin
      @(posedge bit_clk);
      sdata <= fbit(i);
      if (i == 15) sync <= 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge bit_clk);
      sdata <= 1'b0;
    end
  endtask

  task automatic snap();
    w0 = wr_n; r0 = rd_n; l0 = pl_n; q0 = pr_n;
  endtask

  task automatic t_reset();
    chk("R1", "wr_valid", {31'b0, wr_valid}, 0);
    chk("R1", "rd_valid", {31'b0, rd_valid}, 0);
    chk("R1", "pcm valids", {30'b0, pcm_l_valid, pcm_r_valid}, 0);
    chk("R1", "wr_idx/data", {9'b0, wr_idx, wr_data}, 0);
    chk("R1", "rd_idx", {25'b0, rd_idx}, 0);
    chk("R1", "pcm_l", {14'b0, pcm_l}, 0);
    chk("R1", "pcm_r", {14'b0, pcm_r}, 0);
    // serial traffic with no sync rise
    load(16'hFFFF, s1_rd(7'h12), s2_dat(16'hAAAA), 20'hFFFFF, 20'hFFFFF, 20'h0);
    snap();
    for (int i = 0; i < 300; i++) begin
      @(posedge bit_clk);
      sdata <= fbit(i % 256);
    end
    idle(4);
    chk("R1", "events without sync", wr_n - w0 + rd_n - r0 + pl_n - l0 + pr_n - q0, 0);
  endtask

  task automatic t_write();
    load(mk_tag(1, 1, 1, 0, 0), s1_wr(7'h2A), s2_dat(16'hBEEF), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R4", "write count", wr_n - w0, 1);
    chk("R4", "write position", wr_pos, 57);
    chk("R4", "wr_idx", {25'b0, wr_idx}, 32'h2A);
    chk("R4", "wr_data", {16'b0, wr_data}, 32'hBEEF);
    chk("R4", "no read on write", rd_n - r0, 0);
  endtask

  task automatic t_read();
    load(mk_tag(1, 1, 1, 0, 0), s1_rd(7'h26), s2_dat(16'h1234), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R5", "read count", rd_n - r0, 1);
    chk("R5", "read position", rd_pos, 37);
    chk("R5", "rd_idx", {25'b0, rd_idx}, 32'h26);
    chk("R6", "no write on read", wr_n - w0, 0);
    load(mk_tag(1, 1, 1, 0, 0), s1_wr(7'h11), s2_dat(16'h0F0F), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R5", "rd_idx held", {25'b0, rd_idx}, 32'h26);
    chk("R5", "no read on write frame", rd_n - r0, 0);
    chk("R4", "second write idx", {25'b0, wr_idx}, 32'h11);
  endtask

  task automatic t_pcm();
    logic [19:0] lv, rv, lv2;
    lv = 20'hABCDE; rv = 20'h13579; lv2 = 20'h80001;
    load(mk_tag(1, 0, 0, 1, 1), 20'h0, 20'h0, lv, rv, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R7", "left count", pl_n - l0, 1);
    chk("R7", "right count", pr_n - q0, 1);
    chk("R7", "left position", pl_pos, 77);
    chk("R7", "right position", pr_pos, 97);
    chk("R7", "pcm_l", {14'b0, pcm_l}, {14'b0, lv[19:2]});
    chk("R7", "pcm_r", {14'b0, pcm_r}, {14'b0, rv[19:2]});
    load(mk_tag(1, 0, 0, 1, 0), 20'h0, 20'h0, lv2, 20'hFFFFF, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R7", "left only count", pl_n - l0, 1);
    chk("R7", "right lane idle", pr_n - q0, 0);
    chk("R7", "pcm_l updated", {14'b0, pcm_l}, {14'b0, lv2[19:2]});
    chk("R7", "pcm_r kept", {14'b0, pcm_r}, {14'b0, rv[19:2]});
  endtask

  task automatic t_invalid();
    logic [17:0] l_was, r_was;
    logic [6:0]  i_was;
    l_was = pcm_l; r_was = pcm_r; i_was = rd_idx;
    load(mk_tag(0, 1, 1, 1, 1), s1_rd(7'h7F), s2_dat(16'hFFFF), 20'h55555, 20'h33333, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R3", "events in invalid frame", wr_n - w0 + rd_n - r0 + pl_n - l0 + pr_n - q0, 0);
    chk("R3", "rd_idx kept", {25'b0, rd_idx}, {25'b0, i_was});
    chk("R3", "pcm_l kept", {14'b0, pcm_l}, {14'b0, l_was});
    chk("R3", "pcm_r kept", {14'b0, pcm_r}, {14'b0, r_was});
  endtask

  task automatic t_gating();
    load(mk_tag(1, 1, 0, 0, 0), s1_wr(7'h01), s2_dat(16'h1111), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R6", "no write without slot2 flag", wr_n - w0, 0);
    load(mk_tag(1, 0, 1, 0, 0), s1_rd(7'h02), s2_dat(16'h2222), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(256);
    idle(2);
    chk("R6", "no write without slot1 flag", wr_n - w0, 0);
    chk("R5", "no read without slot1 flag", rd_n - r0, 0);
  endtask

  task automatic t_reserved();
    logic [19:0] lv, rv;
    lv = 20'h12343; rv = 20'hFEDCB;
    load(16'hFFFF, {1'b0, 7'h55, 12'hFFF}, {16'hC3A5, 4'hF}, lv, rv, 20'hFFFFF);
    snap();
    send_frame(256);
    idle(2);
    chk("R8", "write count", wr_n - w0, 1);
    chk("R8", "wr_idx", {25'b0, wr_idx}, 32'h55);
    chk("R8", "wr_data", {16'b0, wr_data}, 32'hC3A5);
    chk("R8", "no read", rd_n - r0, 0);
    chk("R8", "pcm_l", {14'b0, pcm_l}, {14'b0, lv[19:2]});
    chk("R8", "pcm_r", {14'b0, pcm_r}, {14'b0, rv[19:2]});
  endtask

  task automatic t_restart();
    logic [6:0] i_was;
    // cut a write frame after slot 1, then a clean write frame
    load(mk_tag(1, 1, 1, 0, 0), s1_wr(7'h33), s2_dat(16'h7777), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(40);
    load(mk_tag(1, 1, 1, 0, 0), s1_wr(7'h44), s2_dat(16'h8888), 20'h0, 20'h0, 20'h0);
    send_frame(256);
    idle(2);
    chk("R9", "one write after restart", wr_n - w0, 1);
    chk("R9", "restarted position", wr_pos, 57);
    chk("R9", "wr_idx from new frame", {25'b0, wr_idx}, 32'h44);
    chk("R9", "wr_data from new frame", {16'b0, wr_data}, 32'h8888);
    // cut a read frame before slot 1 ends, follow with an invalid frame
    i_was = rd_idx;
    load(mk_tag(1, 1, 0, 0, 0), s1_rd(7'h5A), 20'h0, 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(30);
    load(mk_tag(0, 0, 0, 0, 0), 20'h0, 20'h0, 20'h0, 20'h0, 20'h0);
    send_frame(256);
    idle(2);
    chk("R9", "no read from cut frame", rd_n - r0, 0);
    chk("R9", "rd_idx kept", {25'b0, rd_idx}, {25'b0, i_was});
    // cut a write between slot 1 and slot 2 end, then invalid frame with slot 2 ones
    load(mk_tag(1, 1, 1, 0, 0), s1_wr(7'h66), s2_dat(16'h9999), 20'h0, 20'h0, 20'h0);
    snap();
    send_frame(50);
    load(mk_tag(0, 0, 1, 0, 0), 20'h0, 20'hFFFFF, 20'h0, 20'h0, 20'h0);
    send_frame(256);
    idle(2);
    chk("R9", "no stale write", wr_n - w0, 0);
  endtask

  task automatic t_trailing();
    load(mk_tag(1, 1, 1, 1, 1), s1_wr(7'h0C), s2_dat(16'h4321), 20'h11111, 20'h22222, 20'h0);
    snap();
    send_frame(256);
    for (int i = 0; i < 300; i++) begin
      @(posedge bit_clk);
      sdata <= fbit(i % 256);
    end
    idle(2);
    chk("R2", "writes with trailing bits", wr_n - w0, 1);
    chk("R2", "left samples with trailing bits", pl_n - l0, 1);
    chk("R2", "right samples with trailing bits", pr_n - q0, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    sync  = 1'b0;
    sdata = 1'b0;
    repeat (3) @(posedge bit_clk);
    t_reset_during();
    rst_n <= 1'b1;
    idle(3);
    t_reset();
    t_write();
    t_read();
    t_pcm();
    t_invalid();
    t_gating();
    t_reserved();
    t_restart();
    t_trailing();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_during();
    chk("R1", "strobes in reset", {28'b0, wr_valid, rd_valid, pcm_l_valid, pcm_r_valid}, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule